// File: doc/BRIEF.md
# Playback Status Pin Driver

This block turns the internal playback state of a sound player into two general-purpose status pins. It watches the raw playback-active level, a one-cycle end-of-group event with that group's stop-pulse enable, and a one-cycle sample tick. From these it derives four candidate signals: a delayed BUSY level, a fixed-width STOP pulse after a group ends, and two LED flash signals that alternate while playback runs.

A 2-bit chip-wide mapping code selects which two of the four candidates reach the pins. Every time interval counts sample ticks, not clock cycles, so all timings scale with the sample rate. With default parameters and an 8 kHz tick, BUSY lags by one tick (about 125 µs). STOP starts two ticks after the end event and lasts 512 ticks (64 ms). The LEDs flash at roughly 3 Hz.

Top module: `play_status_out`

## Requirements
- R1: With `map_sel` = 2'b00, `pin_a` carries LED2 and `pin_b` carries LED1.
- R2: With `map_sel` = 2'b01, `pin_a` carries LED2 and `pin_b` carries STOP.
- R3: With `map_sel` = 2'b10, `pin_a` carries LED2 and `pin_b` carries BUSY.
- R4: With `map_sel` = 2'b11, `pin_a` carries STOP and `pin_b` carries BUSY.
- R5: BUSY copies `play_busy` after BUSY_DLY sample ticks, on both rising and falling edges, and changes only in the cycle after a tick.
- R6: STOP goes high on the STOP_DLY-th tick after an enabled end event and stays high for exactly STOP_LEN ticks.
- R7: An end event whose `grp_stop_en` is low produces no STOP pulse.
- R8: A rising edge of `play_busy` cancels a STOP pulse that is pending or already high, so STOP is low in the next cycle.
- R9: While `play_busy` is high, LED1 is high for the first LED_HALF ticks. LED1 and LED2 then swap every LED_HALF ticks and are never high together. Without ticks the LEDs hold their state.
- R10: One cycle after `play_busy` is low, both LEDs are low.
- R11: After reset, both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample-rate tick |
| play_busy | input | 1 | Raw playback-active level |
| grp_end | input | 1 | One-cycle end-of-group event |
| grp_stop_en | input | 1 | Stop-pulse enable of the ending group, valid with `grp_end` |
| map_sel | input | 2 | Pin mapping code (see R1 to R4) |
| pin_a | output | 1 | First status pin |
| pin_b | output | 1 | Second status pin |

## Verification
The bench counts ticks exactly at the pulse boundaries. A STOP counter that is off by one would leave the pulse high one tick too long or start it one tick early. It starts playback both during the STOP delay and during the pulse. A design without cancellation would still raise STOP while the next group plays. It also ends a group with the stop enable low, idles, and stalls the tick while busy. A design that ignores the enable, leaves the LEDs lit after playback, or counts clock cycles instead of ticks would show a wrong pin level at one of these sample points.

// File: rtl/pso_pkg.sv
package pso_pkg;
    typedef enum logic [1:0] {
        MAP_LED_LED   = 2'b00,
        MAP_LED_STOP  = 2'b01,
        MAP_LED_BUSY  = 2'b10,
        MAP_STOP_BUSY = 2'b11
    } map_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_PULSE = 2'b10
    } stop_st_e;
endpackage

// File: rtl/pso_busy_delay.sv
module pso_busy_delay #(
    parameter int BUSY_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic busy_raw,
    output logic busy_dly
);
    typedef struct packed {
        logic [BUSY_DLY-1:0] sr;
    } dly_t;

    dly_t s_d, s_q;

    generate
        if (BUSY_DLY == 1) begin : g_single
            always_comb begin
                s_d = s_q;
                if (tick) s_d.sr = busy_raw;
            end
        end else begin : g_chain
            always_comb begin
                s_d = s_q;
                if (tick) s_d.sr = {s_q.sr[BUSY_DLY-2:0], busy_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_dly = s_q.sr[BUSY_DLY-1];
endmodule

// File: rtl/pso_stop_gen.sv
module pso_stop_gen
    import pso_pkg::*;
#(
    parameter int STOP_DLY = 2,
    parameter int STOP_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic done,
    input  logic done_en,
    output logic stop
);
    localparam int MAXC = (STOP_DLY > STOP_LEN) ? STOP_DLY : STOP_LEN;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        stop_st_e        st;
        logic [CW-1:0]   cnt;
    } stop_t;

    stop_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
        end else if (done && done_en) begin
            s_d.st  = ST_WAIT;
            s_d.cnt = '0;
        end else if (tick) begin
            case (s_q.st)
                ST_WAIT: begin
                    if (s_q.cnt == CW'(STOP_DLY - 1)) begin
                        s_d.st  = ST_PULSE;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (s_q.cnt == CW'(STOP_LEN - 1)) begin
                        s_d.st  = ST_IDLE;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign stop = (s_q.st == ST_PULSE);
endmodule

// File: rtl/pso_led_flash.sv
module pso_led_flash #(
    parameter int LED_HALF = 1333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic busy_raw,
    output logic led1,
    output logic led2
);
    localparam int CW = $clog2(LED_HALF + 1);

    typedef struct packed {
        logic          on;
        logic          phase;
        logic [CW-1:0] cnt;
    } led_t;

    led_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!busy_raw) begin
            s_d = '0;
        end else begin
            s_d.on = 1'b1;
            if (tick) begin
                if (s_q.cnt == CW'(LED_HALF - 1)) begin
                    s_d.cnt   = '0;
                    s_d.phase = ~s_q.phase;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign led1 = s_q.on & ~s_q.phase;
    assign led2 = s_q.on &  s_q.phase;
endmodule

// File: rtl/play_status_out.sv
module play_status_out
    import pso_pkg::*;
#(
    parameter int BUSY_DLY = 1,
    parameter int STOP_DLY = 2,
    parameter int STOP_LEN = 512,
    parameter int LED_HALF = 1333
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_tick,
    input  logic       play_busy,
    input  logic       grp_end,
    input  logic       grp_stop_en,
    input  logic [1:0] map_sel,
    output logic       pin_a,
    output logic       pin_b
);
    typedef struct packed {
        logic busy_prev;
    } top_t;

    top_t s_d, s_q;
    logic start_w, busy_w, stop_w, led1_w, led2_w;

    always_comb begin
        s_d           = s_q;
        s_d.busy_prev = play_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_w = play_busy & ~s_q.busy_prev;

    pso_busy_delay #(.BUSY_DLY(BUSY_DLY)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (smp_tick),
        .busy_raw (play_busy),
        .busy_dly (busy_w)
    );

    pso_stop_gen #(.STOP_DLY(STOP_DLY), .STOP_LEN(STOP_LEN)) u_stop (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (smp_tick),
        .start   (start_w),
        .done    (grp_end),
        .done_en (grp_stop_en),
        .stop    (stop_w)
    );

    pso_led_flash #(.LED_HALF(LED_HALF)) u_led (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (smp_tick),
        .busy_raw (play_busy),
        .led1     (led1_w),
        .led2     (led2_w)
    );

    always_comb begin
        case (map_e'(map_sel))
            MAP_LED_LED:   begin pin_a = led2_w; pin_b = led1_w; end
            MAP_LED_STOP:  begin pin_a = led2_w; pin_b = stop_w; end
            MAP_LED_BUSY:  begin pin_a = led2_w; pin_b = busy_w; end
            default:       begin pin_a = stop_w; pin_b = busy_w; end
        endcase
    end
endmodule

// File: rtl/pso_chk.sv
module pso_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_tick,
    input logic       play_busy,
    input logic [1:0] map_sel,
    input logic       pin_a,
    input logic       pin_b
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R9
    led_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_sel == 2'b00) |-> !(pin_a && pin_b));

    // R10
    led_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_busy && map_sel == 2'b00) |=> (map_sel != 2'b00 || (!pin_a && !pin_b)));

    // R8
    stop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && map_sel == 2'b11 && play_busy && !$past(play_busy))
        |=> (map_sel != 2'b11 || !pin_a));

    // R6
    stop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && map_sel == 2'b11 && $past(map_sel) == 2'b11 && $rose(pin_a))
        |-> $past(smp_tick));

    // R5
    busy_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && map_sel == 2'b11 && $past(map_sel) == 2'b11 && pin_b != $past(pin_b))
        |-> $past(smp_tick));
endmodule

bind play_status_out pso_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_tick  (smp_tick),
    .play_busy (play_busy),
    .map_sel   (map_sel),
    .pin_a     (pin_a),
    .pin_b     (pin_b)
);

// File: tb/play_status_out_test.sv
module play_status_out_test;
    localparam int BD = 1;
    localparam int SD = 2;
    localparam int SL = 8;
    localparam int LH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_tick = 1'b0;
    logic play_busy = 1'b0;
    logic grp_end = 1'b0;
    logic grp_stop_en = 1'b0;
    logic [1:0] map_sel = 2'b00;
    logic pin_a, pin_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    play_status_out #(.BUSY_DLY(BD), .STOP_DLY(SD), .STOP_LEN(SL), .LED_HALF(LH)) uut (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .play_busy(play_busy),
        .grp_end(grp_end), .grp_stop_en(grp_stop_en), .map_sel(map_sel),
        .pin_a(pin_a), .pin_b(pin_b)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            smp_tick = 1'b1;
            cyc();
            smp_tick = 1'b0;
        end
    endtask

    task automatic idle();
        play_busy = 1'b0; grp_end = 1'b0; grp_stop_en = 1'b0;
        tk(2);
        cyc();
    endtask

    task automatic end_group(input logic en);
        play_busy = 1'b1; cyc();
        play_busy = 1'b0; grp_end = 1'b1; grp_stop_en = en; cyc();
        grp_end = 1'b0; grp_stop_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 pin_a", pin_a, 1'b0);
        chk("R11 pin_b", pin_b, 1'b0);
    endtask

    task automatic t_busy();
        map_sel = 2'b11; idle();
        play_busy = 1'b1; cyc();
        chk("R5 no tick yet", pin_b, 1'b0);
        cyc();
        chk("R5 still waiting", pin_b, 1'b0);
        tk(1);
        chk("R5 rise after tick", pin_b, 1'b1);
        play_busy = 1'b0; cyc();
        chk("R5 fall waits", pin_b, 1'b1);
        tk(1);
        chk("R5 fall after tick", pin_b, 1'b0);
    endtask

    task automatic t_stop();
        map_sel = 2'b11; idle();
        end_group(1'b1);
        chk("R6 not immediate", pin_a, 1'b0);
        tk(1);
        chk("R6 delay tick 1", pin_a, 1'b0);
        tk(1);
        chk("R6 rises on delay tick", pin_a, 1'b1);
        tk(SL - 1);
        chk("R4 R6 last pulse tick", pin_a, 1'b1);
        tk(1);
        chk("R6 falls after width", pin_a, 1'b0);
    endtask

    task automatic t_stop_off();
        bit seen = 1'b0;
        map_sel = 2'b11; idle();
        end_group(1'b0);
        for (int i = 0; i < SD + SL + 2; i++) begin
            tk(1);
            if (pin_a) seen = 1'b1;
        end
        chk("R7 no pulse when disabled", seen, 1'b0);
    endtask

    task automatic t_cancel();
        map_sel = 2'b11; idle();
        end_group(1'b1);
        tk(SD + 1);
        chk("R8 pulse active", pin_a, 1'b1);
        play_busy = 1'b1; cyc();
        chk("R8 start cancels pulse", pin_a, 1'b0);
        tk(SL);
        chk("R8 stays cancelled", pin_a, 1'b0);
        idle();
        end_group(1'b1);
        tk(1);
        play_busy = 1'b1; cyc();
        tk(SD + 1);
        chk("R8 start cancels pending", pin_a, 1'b0);
    endtask

    task automatic t_led();
        map_sel = 2'b00; idle();
        play_busy = 1'b1; cyc();
        chk("R1 R9 LED1 first on pin_b", pin_b, 1'b1);
        chk("R1 R9 LED2 off on pin_a", pin_a, 1'b0);
        repeat (10) cyc();
        chk("R9 holds without ticks", pin_b, 1'b1);
        tk(LH - 1);
        chk("R9 before swap", pin_b, 1'b1);
        tk(1);
        chk("R9 swap pin_a", pin_a, 1'b1);
        chk("R9 swap pin_b", pin_b, 1'b0);
        tk(LH);
        chk("R9 swap back", pin_b, 1'b1);
        play_busy = 1'b0; cyc();
        chk("R10 pin_a idle", pin_a, 1'b0);
        chk("R10 pin_b idle", pin_b, 1'b0);
    endtask

    task automatic t_map1();
        map_sel = 2'b01; idle();
        end_group(1'b1);
        tk(SD);
        chk("R2 STOP on pin_b", pin_b, 1'b1);
        chk("R2 LED2 off on pin_a", pin_a, 1'b0);
        idle();
        tk(SL);
    endtask

    task automatic t_map2();
        map_sel = 2'b10; idle();
        play_busy = 1'b1; cyc();
        chk("R3 BUSY delayed on pin_b", pin_b, 1'b0);
        tk(1);
        chk("R3 BUSY on pin_b", pin_b, 1'b1);
        tk(LH - 1);
        chk("R3 LED2 on pin_a", pin_a, 1'b1);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_busy();
        t_stop();
        t_stop_off();
        t_cancel();
        t_led();
        t_map1();
        t_map2();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule